// File: doc/BRIEF.md
# Timing Pulse Sequencer

This block is the state machine that paces one instruction sub-sequence through a fixed run of timing pulses, twelve by default. It also sequences the machine through a power-up idle state, a debug path (a switch-release state followed by a single-step wait state) and a standby state. Every transition is gated by a clock enable that marks a slightly delayed phase-one pulse. Between enables the state is frozen, whatever the other inputs do.

After the last pulse of a sub-sequence the machine picks its next destination. A breakpoint hit takes priority and goes toward the wait state. Without a breakpoint, the standby switch sends it to standby. Without either, free-run mode wraps it back to the first pulse. With none of the three set, it goes toward the wait state. The wait state is never entered directly: the path always passes through the switch-release state, which holds until the operator's switches are released. The outputs are a one-hot pulse vector for the control lookup downstream, a numeric code for each state for display and debug, and two status flags.

Top module: `tp_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge, enable not required) puts the machine in the idle start-up state. In that state the code is 0, all pulse bits are 0, and both flags are 0.
- R2: On a clock edge where `p1_en` is low, the state does not change, whatever the other inputs are.
- R3: The idle state holds on enabled edges while `start_i` is low. An enabled edge with `start_i` high moves it to the first pulse: code 1, `tp_o` bit 0 set.
- R4: Pulse k (code k, `tp_o` bit k-1, for k from 1 to N-1) moves to pulse k+1 on every enabled edge. `start_i`, `bkpt_i`, `stby_sw_i`, `free_run_i` and `run_i` have no effect during these pulses.
- R5: At the last pulse (code N), an enabled edge with `bkpt_i` high goes to the switch-release state (code N+1), whatever the standby and free-run inputs are.
- R6: At the last pulse, with `bkpt_i` low and `stby_sw_i` high, an enabled edge goes to standby (code N+3, `stby_o` high).
- R7: At the last pulse, with `bkpt_i` and `stby_sw_i` low and `free_run_i` high, an enabled edge wraps to the first pulse (code 1).
- R8: At the last pulse, with `bkpt_i`, `stby_sw_i` and `free_run_i` all low, an enabled edge goes to the switch-release state (code N+1).
- R9: The switch-release state holds on enabled edges while `sw_rel_i` is low. An enabled edge with `sw_rel_i` high moves it to the wait state (code N+2, `wait_o` high).
- R10: The wait state holds on enabled edges while `run_i` is low. An enabled edge with `run_i` high moves it to the first pulse.
- R11: Standby holds on enabled edges while `stby_sw_i` is high. An enabled edge with `stby_sw_i` low returns the machine to the idle state (code 0).
- R12: `tp_o` has at most one bit set, and it is all zeros in every state that is not a pulse. `wait_o` is high only with code N+2, and `stby_o` only with code N+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| p1_en | input | 1 | Delayed phase-one enable; transitions happen only when it is high |
| start_i | input | 1 | Leave the idle start-up state |
| run_i | input | 1 | Single-step: leave the wait state for the first pulse |
| bkpt_i | input | 1 | Breakpoint hit, sampled at the last pulse |
| stby_sw_i | input | 1 | Standby switch |
| free_run_i | input | 1 | Free-run mode select |
| sw_rel_i | input | 1 | Switches released indication |
| tp_o | output | NUM_PULSES | One-hot timing pulse, bit k-1 for pulse k |
| code_o | output | CODE_W | Numeric state code: 0 idle, 1..N pulses, N+1 switch release, N+2 wait, N+3 standby |
| wait_o | output | 1 | High in the wait state |
| stby_o | output | 1 | High in standby |

## Verification
Every output comes straight from a single state register through decode logic. Each result is therefore due at the first rising edge where `p1_en` is high after its inputs are set, or at the edge with `rst` high. The bench changes inputs at the falling edge, lets exactly one rising edge pass, and compares all four outputs at the next falling edge against a code it computes from the requirements. Each enabled step is preceded by a disabled edge carrying conflicting inputs, to show that nothing moves early. All eight combinations of breakpoint, standby and free-run are swept at the last pulse, and each resulting path is followed back to a pulse or to idle.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PULSE = 3'd1,
    M_SWREL = 3'd2,
    M_WAIT  = 3'd3,
    M_STBY  = 3'd4
  } mode_e;

  // Destination after the final pulse: breakpoint over standby over free run.
  function automatic mode_e last_pulse_exit(input logic bkpt, input logic stby,
                                            input logic free);
    if (bkpt)      return M_SWREL;
    else if (stby) return M_STBY;
    else if (free) return M_PULSE;
    else           return M_SWREL;
  endfunction

  // Numeric code: 0 idle, 1..n pulses, then switch release, wait, standby.
  function automatic int unsigned code_of(input mode_e m, input int unsigned idx,
                                          input int unsigned n);
    case (m)
      M_PULSE: return idx + 1;
      M_SWREL: return n + 1;
      M_WAIT:  return n + 2;
      M_STBY:  return n + 3;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tps_pulse_ctr.sv
module tps_pulse_ctr #(
  parameter int NUM_PULSES = 12,
  localparam int IDX_W = $clog2(NUM_PULSES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_first,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             is_last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PULSES - 1);

  always_ff @(posedge clk) begin
    if (rst)              idx <= '0;
    else if (enter_first) idx <= '0;
    else if (step)        idx <= idx + 1'b1;
  end

  assign is_last = (idx == LAST_IDX);

endmodule

// File: rtl/tps_mode_fsm.sv
module tps_mode_fsm
  import tps_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  p1_en,
  input  logic  start_i,
  input  logic  run_i,
  input  logic  bkpt_i,
  input  logic  stby_sw_i,
  input  logic  free_run_i,
  input  logic  sw_rel_i,
  input  logic  is_last,
  output mode_e mode,
  output logic  enter_first,
  output logic  step
);

  mode_e mode_nxt;

  always_comb begin
    mode_nxt    = mode;
    enter_first = 1'b0;
    step        = 1'b0;
    if (p1_en) begin
      case (mode)
        M_IDLE: if (start_i) begin
          mode_nxt    = M_PULSE;
          enter_first = 1'b1;
        end
        M_PULSE: begin
          if (!is_last) begin
            step = 1'b1;
          end else begin
            mode_nxt    = last_pulse_exit(bkpt_i, stby_sw_i, free_run_i);
            enter_first = (mode_nxt == M_PULSE);
          end
        end
        M_SWREL: if (sw_rel_i) mode_nxt = M_WAIT;
        M_WAIT: if (run_i) begin
          mode_nxt    = M_PULSE;
          enter_first = 1'b1;
        end
        M_STBY: if (!stby_sw_i) mode_nxt = M_IDLE;
        default: mode_nxt = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= M_IDLE;
    else     mode <= mode_nxt;
  end

endmodule

// File: rtl/tps_decode.sv
module tps_decode
  import tps_pkg::*;
#(
  parameter int NUM_PULSES = 12,
  localparam int IDX_W  = $clog2(NUM_PULSES),
  localparam int CODE_W = $clog2(NUM_PULSES + 4)
) (
  input  mode_e             mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [NUM_PULSES-1:0] tp_o,
  output logic [CODE_W-1:0] code_o,
  output logic              wait_o,
  output logic              stby_o
);

  for (genvar i = 0; i < NUM_PULSES; i++) begin : g_tp
    assign tp_o[i] = (mode == M_PULSE) && (idx == IDX_W'(i));
  end

  assign code_o = CODE_W'(code_of(mode, int'(idx), NUM_PULSES));
  assign wait_o = (mode == M_WAIT);
  assign stby_o = (mode == M_STBY);

endmodule

// File: rtl/tp_sequencer.sv
module tp_sequencer
  import tps_pkg::*;
#(
  parameter int NUM_PULSES = 12,
  localparam int IDX_W  = $clog2(NUM_PULSES),
  localparam int CODE_W = $clog2(NUM_PULSES + 4)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  p1_en,
  input  logic                  start_i,
  input  logic                  run_i,
  input  logic                  bkpt_i,
  input  logic                  stby_sw_i,
  input  logic                  free_run_i,
  input  logic                  sw_rel_i,
  output logic [NUM_PULSES-1:0] tp_o,
  output logic [CODE_W-1:0]     code_o,
  output logic                  wait_o,
  output logic                  stby_o
);

  mode_e            mode;
  logic [IDX_W-1:0] idx;
  logic             is_last;
  logic             enter_first;
  logic             step;

  tps_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .p1_en      (p1_en),
    .start_i    (start_i),
    .run_i      (run_i),
    .bkpt_i     (bkpt_i),
    .stby_sw_i  (stby_sw_i),
    .free_run_i (free_run_i),
    .sw_rel_i   (sw_rel_i),
    .is_last    (is_last),
    .mode       (mode),
    .enter_first(enter_first),
    .step       (step)
  );

  tps_pulse_ctr #(.NUM_PULSES(NUM_PULSES)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .enter_first(enter_first),
    .step       (step),
    .idx        (idx),
    .is_last    (is_last)
  );

  tps_decode #(.NUM_PULSES(NUM_PULSES)) u_dec (
    .mode  (mode),
    .idx   (idx),
    .tp_o  (tp_o),
    .code_o(code_o),
    .wait_o(wait_o),
    .stby_o(stby_o)
  );

endmodule

// File: rtl/tps_chk.sv
module tps_chk #(
  parameter int NUM_PULSES = 12,
  parameter int CODE_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  p1_en,
  input logic                  start_i,
  input logic                  run_i,
  input logic                  bkpt_i,
  input logic                  stby_sw_i,
  input logic                  sw_rel_i,
  input logic [NUM_PULSES-1:0] tp_o,
  input logic [CODE_W-1:0]     code_o,
  input logic                  wait_o,
  input logic                  stby_o,
  input logic                  enter_first,
  input logic                  step
);

  localparam logic [CODE_W-1:0] C_IDLE  = '0;
  localparam logic [CODE_W-1:0] C_FIRST = CODE_W'(1);
  localparam logic [CODE_W-1:0] C_LAST  = CODE_W'(NUM_PULSES);
  localparam logic [CODE_W-1:0] C_SWREL = CODE_W'(NUM_PULSES + 1);
  localparam logic [CODE_W-1:0] C_WAIT  = CODE_W'(NUM_PULSES + 2);
  localparam logic [CODE_W-1:0] C_STBY  = CODE_W'(NUM_PULSES + 3);

  logic in_pulse;
  assign in_pulse = (code_o >= C_FIRST) && (code_o <= C_LAST);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (code_o == C_IDLE && tp_o == '0));

  // R2
  hold_no_en_chk: assert property (@(posedge clk) disable iff (rst)
    !p1_en |=> $stable(code_o));

  // R2
  no_ctl_no_en_chk: assert property (@(posedge clk) disable iff (rst)
    !p1_en |-> !enter_first && !step);

  // R3
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (code_o == C_IDLE && p1_en && start_i) |=> code_o == C_FIRST);

  // R4
  pulse_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (in_pulse && code_o != C_LAST && p1_en) |=> code_o == $past(code_o) + 1'b1);

  // R5
  bkpt_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (code_o == C_LAST && p1_en && bkpt_i) |=> code_o == C_SWREL);

  // R6
  stby_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (code_o == C_LAST && p1_en && !bkpt_i && stby_sw_i) |=> stby_o);

  // R9
  swrel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (code_o == C_SWREL && !(p1_en && sw_rel_i)) |=> code_o == C_SWREL);

  // R10
  wait_run_chk: assert property (@(posedge clk) disable iff (rst)
    (code_o == C_WAIT && p1_en && run_i) |=> code_o == C_FIRST);

  // R11
  stby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (code_o == C_STBY && stby_sw_i) |=> code_o == C_STBY);

  // R12
  tp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tp_o) && ((tp_o != '0) == in_pulse));

  // R12
  flag_code_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_o == (code_o == C_WAIT)) && (stby_o == (code_o == C_STBY)));

endmodule

bind tp_sequencer tps_chk #(.NUM_PULSES(NUM_PULSES), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .p1_en      (p1_en),
  .start_i    (start_i),
  .run_i      (run_i),
  .bkpt_i     (bkpt_i),
  .stby_sw_i  (stby_sw_i),
  .sw_rel_i   (sw_rel_i),
  .tp_o       (tp_o),
  .code_o     (code_o),
  .wait_o     (wait_o),
  .stby_o     (stby_o),
  .enter_first(enter_first),
  .step       (step)
);

// File: tb/tp_sequencer_tb.sv
module tp_sequencer_tb;

  localparam int N  = 12;
  localparam int CW = $clog2(N + 4);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p1_en = 1'b0, start_i = 1'b0, run_i = 1'b0, bkpt_i = 1'b0;
  logic stby_sw_i = 1'b0, free_run_i = 1'b0, sw_rel_i = 1'b0;
  logic [N-1:0]  tp_o;
  logic [CW-1:0] code_o;
  logic wait_o, stby_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tp_sequencer #(.NUM_PULSES(N)) u_dut (
    .clk(clk), .rst(rst), .p1_en(p1_en), .start_i(start_i), .run_i(run_i),
    .bkpt_i(bkpt_i), .stby_sw_i(stby_sw_i), .free_run_i(free_run_i),
    .sw_rel_i(sw_rel_i), .tp_o(tp_o), .code_o(code_o), .wait_o(wait_o),
    .stby_o(stby_o)
  );

  // One rising edge passes; inputs were set at a falling edge, sample at the next.
  task automatic tick(input logic en);
    p1_en = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_code(input string req, input int exp);
    logic [N-1:0] exp_tp;
    bit ok;
    exp_tp = (exp >= 1 && exp <= N) ? (N'(1) << (exp - 1)) : '0;
    ok = (int'(code_o) == exp) && (tp_o == exp_tp) &&
         (wait_o == (exp == N + 2)) && (stby_o == (exp == N + 3));
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: code=%0d tp=%b wait=%b stby=%b expected code=%0d tp=%b wait=%b stby=%b",
               req, code_o, tp_o, wait_o, stby_o, exp, exp_tp,
               exp == N + 2, exp == N + 3);
    end
  endtask

  function automatic int tp_end_code(input bit b, input bit s, input bit f);
    return b ? N + 1 : (s ? N + 3 : (f ? 1 : N + 1));
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: code=%0d expected run to finish", code_o);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      bit b, s, f;
      int exp;
      b = c[2]; s = c[1]; f = c[0];
      rst = 1'b1; start_i = 0; run_i = 0; bkpt_i = 0; stby_sw_i = 0;
      free_run_i = 0; sw_rel_i = 0;
      tick(1'b0);
      expect_code("R1 reset", 0);
      rst = 1'b0;
      tick(1'b1);
      expect_code("R3 idle hold", 0);
      start_i = 1'b1;
      tick(1'b0);
      expect_code("R2 idle no enable", 0);
      tick(1'b1);
      expect_code("R3 start", 1);
      for (int k = 2; k <= N; k++) begin
        start_i = 1; bkpt_i = 1; stby_sw_i = 1; run_i = 1;
        tick(1'b0);
        expect_code("R2 pulse no enable", k - 1);
        free_run_i = 0;
        tick(1'b1);
        expect_code("R4 pulse advance", k);
      end
      start_i = 0; run_i = 0;
      bkpt_i = b; stby_sw_i = s; free_run_i = f;
      tick(1'b0);
      expect_code("R2 last pulse no enable", N);
      tick(1'b1);
      exp = tp_end_code(b, s, f);
      if (b)      expect_code("R5 breakpoint priority", exp);
      else if (s) expect_code("R6 standby", exp);
      else if (f) expect_code("R7 free run wrap", exp);
      else        expect_code("R8 default to switch release", exp);
      bkpt_i = 0; free_run_i = 0;
      if (exp == N + 1) begin
        stby_sw_i = 0;
        tick(1'b1);
        expect_code("R9 switch release hold", N + 1);
        sw_rel_i = 1;
        tick(1'b0);
        expect_code("R2 switch release no enable", N + 1);
        tick(1'b1);
        expect_code("R9 enter wait", N + 2);
        sw_rel_i = 0;
        tick(1'b1);
        expect_code("R10 wait hold", N + 2);
        run_i = 1;
        tick(1'b0);
        expect_code("R2 wait no enable", N + 2);
        tick(1'b1);
        expect_code("R10 step to first pulse", 1);
        run_i = 0;
      end else if (exp == N + 3) begin
        tick(1'b1);
        expect_code("R11 standby hold", N + 3);
        stby_sw_i = 0;
        tick(1'b0);
        expect_code("R2 standby no enable", N + 3);
        tick(1'b1);
        expect_code("R11 standby exit to idle", 0);
      end else begin
        tick(1'b1);
        expect_code("R7 continue after wrap", 2);
      end
      rst = 1'b1;
      tick(1'b0);
      expect_code("R1 reset without enable", 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule